// File: doc/BRIEF.md
# Processor power-mode controller

This controller sequences a processor between three power modes: run, where the CPU clock is on and the main logic is powered; idle, where the CPU clock is stopped but the logic keeps its power; and sleep, where the main logic is powered down. Software raises a request that names a target mode, and an interrupt line wakes the processor. The controller has one reference clock that never stops. It times every change of mode with a down-counter on that clock, and it drives a CPU clock-enable and a main-logic power-enable.

Each path between modes has its own duration, and each duration is a parameter given in reference-clock cycles. Going between run and idle takes `T_IDLE` cycles in either direction. Entering sleep from run or from idle passes through three equal steps of `T_STEP` cycles each. Waking from sleep takes `T_WAKE` cycles, which is far longer than any other path, and always ends in run. While a change is in progress the controller raises `busy` and ignores every request and wake event. A two-bit level code reports how much power the processor is currently drawing.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is in run (`mode`=00), with `clk_en`=1, `pwr_en`=1 and `busy`=0.
- R2: A request for idle (`req_mode`=01) in run, or a request for run (`req_mode`=00) in idle, holds `busy` high for exactly `T_IDLE` cycles. The new mode is then settled.
- R3: `clk_en` stays high for the whole run-to-idle change and falls when it ends. It stays low for the whole idle-to-run change and rises when it ends.
- R4: A sleep request (`req_mode`=10) from run or from idle gives three steps of `T_STEP` cycles, so `busy` is high for 3·`T_STEP` cycles with `clk_en` low and `pwr_en` high. `pwr_en` falls only when the third step completes.
- R5: In settled sleep, requests for any mode are ignored, and only `wake_irq` starts a change.
- R6: `wake_irq` in sleep holds `busy` high for `T_WAKE` cycles with `pwr_en` high and `clk_en` low. The controller then settles in run with `clk_en` high. `clk_en` is never high while `pwr_en` is low.
- R7: While `busy` is high, requests and `wake_irq` are ignored. `mode` shows the target of the change in progress from the cycle after it starts.
- R8: `pwr_lvl` is 10 when `clk_en`=1 (run level), 01 when powered with the clock stopped (idle level), and 00 when `pwr_en`=0 (sleep level).
- R9: A request for the mode already settled, a request with code 11, and `wake_irq` while in run all have no effect.
- R10: In idle, `wake_irq` starts an idle-to-run change. It takes priority over a sleep request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 00 run, 01 idle, 10 sleep |
| wake_irq | input | 1 | Wake interrupt |
| clk_en | output | 1 | CPU clock enable |
| pwr_en | output | 1 | Main-logic power enable |
| busy | output | 1 | Change of mode in progress |
| mode | output | 2 | Settled mode, or the target while busy |
| pwr_lvl | output | 2 | Power level code |

## Verification
The bench uses short durations and drives every legal edge between modes: run to idle, and idle back to run both by request and by interrupt. It also enters sleep from both run and idle, and wakes from sleep twice. For each of these it checks `busy`, `clk_en`, `pwr_en`, `mode` and `pwr_lvl` in every cycle of the change and in the first settled cycle. This tells the run–idle timing apart from the three-step sleep entry and the long wake. During every change the bench keeps driving opposing requests and wake pulses, so a controller that lets a change be interrupted is caught. Separate pokes cover requests that must do nothing: a request for the current mode, code 11, a wake in run, and mode requests in sleep. A last case applies a wake and a sleep request together in idle to check which one wins.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int T_IDLE = 10,
  parameter int T_STEP = 30,
  parameter int T_WAKE = 160000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake_irq,
  output logic       clk_en,
  output logic       pwr_en,
  output logic       busy,
  output logic [1:0] mode,
  output logic [1:0] pwr_lvl
);
  localparam int TMAX = (T_WAKE > T_STEP) ? ((T_WAKE > T_IDLE) ? T_WAKE : T_IDLE)
                                          : ((T_STEP > T_IDLE) ? T_STEP : T_IDLE);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [1:0] M_RUN = 2'b00, M_IDLE = 2'b01, M_SLEEP = 2'b10;

  typedef enum logic [3:0] {
    S_RUN, S_TO_IDLE, S_IDLE, S_TO_RUN, S_STEP1, S_STEP2, S_STEP3, S_SLEEP, S_WAKE
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;

  wire ask_idle  = req_valid && req_mode == M_IDLE;
  wire ask_run   = req_valid && req_mode == M_RUN;
  wire ask_sleep = req_valid && req_mode == M_SLEEP;
  wire done      = cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (ask_idle) begin
            st  <= S_TO_IDLE;
            cnt <= CW'(T_IDLE - 1);
          end else if (ask_sleep) begin
            st  <= S_STEP1;
            cnt <= CW'(T_STEP - 1);
          end
        end
        S_IDLE: begin
          if (wake_irq || ask_run) begin
            st  <= S_TO_RUN;
            cnt <= CW'(T_IDLE - 1);
          end else if (ask_sleep) begin
            st  <= S_STEP1;
            cnt <= CW'(T_STEP - 1);
          end
        end
        S_SLEEP: begin
          if (wake_irq) begin
            st  <= S_WAKE;
            cnt <= CW'(T_WAKE - 1);
          end
        end
        default: begin
          if (!done) begin
            cnt <= cnt - 1'b1;
          end else begin
            case (st)
              S_TO_IDLE: st <= S_IDLE;
              S_STEP1: begin st <= S_STEP2; cnt <= CW'(T_STEP - 1); end
              S_STEP2: begin st <= S_STEP3; cnt <= CW'(T_STEP - 1); end
              S_STEP3: st <= S_SLEEP;
              default: st <= S_RUN;
            endcase
          end
        end
      endcase
    end
  end

  assign busy    = !(st == S_RUN || st == S_IDLE || st == S_SLEEP);
  assign clk_en  = st == S_RUN || st == S_TO_IDLE;
  assign pwr_en  = st != S_SLEEP;
  assign pwr_lvl = !pwr_en ? 2'b00 : (clk_en ? 2'b10 : 2'b01);

  always_comb begin
    case (st)
      S_TO_IDLE, S_IDLE:                         mode = M_IDLE;
      S_STEP1, S_STEP2, S_STEP3, S_SLEEP:        mode = M_SLEEP;
      default:                                   mode = M_RUN;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_irq,
  input logic       clk_en,
  input logic       pwr_en,
  input logic       busy,
  input logic [1:0] mode
);
  AST_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !clk_en); // R6
  AST_PWR_OFF_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (mode == 2'b10 && !busy)); // R4
  AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode)); // R7
  AST_SLEEP_ONLY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !busy && !wake_irq) |=> (mode == 2'b10 && !busy)); // R5
  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !busy && wake_irq) |=> (mode == 2'b00 && busy && pwr_en)); // R6
  AST_CLK_RISE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (mode == 2'b00 && !busy)); // R3
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake_irq(wake_irq), .clk_en(clk_en),
  .pwr_en(pwr_en), .busy(busy), .mode(mode)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int TI = 3, TS = 4, TW = 9;

  logic clk = 0, rst_n = 0, req_valid = 0, wake_irq = 0;
  logic [1:0] req_mode = 2'b00;
  logic clk_en, pwr_en, busy;
  logic [1:0] mode, pwr_lvl;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.T_IDLE(TI), .T_STEP(TS), .T_WAKE(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wake_irq(wake_irq), .clk_en(clk_en), .pwr_en(pwr_en), .busy(busy),
    .mode(mode), .pwr_lvl(pwr_lvl)
  );

  task automatic chk(input string tag, input logic eb, input logic ec, input logic ep,
                     input logic [1:0] em);
    logic [1:0] el;
    logic [6:0] act, exp;
    el  = !ep ? 2'b00 : (ec ? 2'b10 : 2'b01);
    act = {busy, clk_en, pwr_en, mode, pwr_lvl};
    exp = {eb, ec, ep, em, el};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s R8: {busy,clk_en,pwr_en,mode,lvl} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic trans(input string tag, input logic use_wake, input logic [1:0] rm,
                       input int t, input logic [1:0] tgt, input logic mclk,
                       input logic fclk, input logic fpwr);
    @(negedge clk);
    req_valid = !use_wake; req_mode = rm; wake_irq = use_wake;
    @(posedge clk);
    for (int k = 1; k <= t; k++) begin
      @(negedge clk);
      if (k < t) begin
        req_valid = 1; req_mode = k[0] ? 2'b01 : 2'b10; wake_irq = k[1];
      end else begin
        req_valid = 0; wake_irq = 0;
      end
      chk($sformatf("%s busy-cycle %0d R7", tag, k), 1'b1, mclk, 1'b1, tgt);
    end
    @(negedge clk);
    chk($sformatf("%s settled", tag), 1'b0, fclk, fpwr, tgt);
  endtask

  task automatic poke(input string tag, input logic v, input logic [1:0] rm, input logic w,
                      input logic ec, input logic ep, input logic [1:0] em);
    @(negedge clk);
    req_valid = v; req_mode = rm; wake_irq = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; wake_irq = 0;
    chk(tag, 1'b0, ec, ep, em);
    @(negedge clk);
    chk(tag, 1'b0, ec, ep, em);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 1'b1, 1'b1, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 1'b1, 1'b1, 2'b00);

    poke("R9 run same-mode", 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 2'b00);
    poke("R9 run code 11", 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 2'b00);
    poke("R9 run wake", 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 2'b00);

    trans("R2 R3 run->idle", 1'b0, 2'b01, TI, 2'b01, 1'b1, 1'b0, 1'b1);
    poke("R9 idle same-mode", 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 2'b01);
    trans("R2 R3 idle->run req", 1'b0, 2'b00, TI, 2'b00, 1'b0, 1'b1, 1'b1);
    trans("R2 run->idle again", 1'b0, 2'b01, TI, 2'b01, 1'b1, 1'b0, 1'b1);
    trans("R3 idle->run wake", 1'b1, 2'b00, TI, 2'b00, 1'b0, 1'b1, 1'b1);

    trans("R4 run->sleep", 1'b0, 2'b10, 3*TS, 2'b10, 1'b0, 1'b0, 1'b0);
    poke("R5 sleep req run", 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b10);
    poke("R5 sleep req idle", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 2'b10);
    trans("R6 wake from sleep", 1'b1, 2'b00, TW, 2'b00, 1'b0, 1'b1, 1'b1);

    trans("R2 run->idle pre-sleep", 1'b0, 2'b01, TI, 2'b01, 1'b1, 1'b0, 1'b1);
    trans("R4 idle->sleep", 1'b0, 2'b10, 3*TS, 2'b10, 1'b0, 1'b0, 1'b0);
    trans("R6 wake again", 1'b1, 2'b00, TW, 2'b00, 1'b0, 1'b1, 1'b1);

    trans("R2 run->idle pre-race", 1'b0, 2'b01, TI, 2'b01, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    req_valid = 1; req_mode = 2'b10; wake_irq = 1;
    @(posedge clk);
    for (int k = 1; k <= TI; k++) begin
      @(negedge clk);
      req_valid = 0; wake_irq = 0;
      chk("R10 wake beats sleep", 1'b1, 1'b0, 1'b1, 2'b00);
    end
    @(negedge clk);
    chk("R10 settled run", 1'b0, 1'b1, 1'b1, 2'b00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule